// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block holds received frames in a circular store divided into 16-byte pages. A frame arrives on a simple valid/data/last stream, one 32-bit beat per cycle. The block writes a one-word length header at the first word of the current page, followed directly by the payload. Once the frame is fully accepted, it moves its current-page pointer forward. The host owns a boundary pointer. Pages from the page after the boundary up to the page before the current pointer hold unread packets. The ring is empty when the page after the boundary equals the current pointer.

To drain the ring, the host:
1. Opens a read window, which loads an internal read pointer with the first word of the page after the boundary.
2. Pulls words through one auto-incrementing data register. The first word is the length header, and the payload follows.
3. Closes the window.
4. Hands the pages back by advancing the boundary by 1 + ceil(len/16) pages, modulo the ring size.

Space is checked beat by beat. A frame that would reach the boundary page, or that is longer than `MAX_LEN` bytes, is discarded as a whole and raises an overflow flag. A stored frame raises a receive flag. Both flags drive one interrupt line.

Top module: `rx_page_ring`

Register map (`reg_addr`): 0 status, 1 current page (read-only), 2 boundary page, 3 read window (bit 0), 4 data port. Reads return data one cycle after `reg_rd`.

## Requirements
- R1: After reset the status register reads 0, the current page reads 0, the boundary reads all ones (2^PAGE_W − 1), so the ring is empty, and `irq` is low.
- R2: A stored frame's first word, read through the data port, holds the frame byte length in bits 15:0, with bits 31:16 zero. The payload follows in later words, little-endian: byte k of the frame sits in word 1 + k/4, bits 8·(k mod 4) upward.
- R3: When a frame is accepted, the current page moves forward by 1 + ceil(len/16), modulo 2^PAGE_W, and status bit 4 (receive) is set.
- R4: A frame is accepted only if 1 + ceil(len/16) ≤ (boundary − current) mod 2^PAGE_W. An exact fit is accepted. Any frame needing more pages is dropped whole, the current page is unchanged, and status bit 0 (overflow) is set.
- R5: A frame longer than `MAX_LEN` bytes is dropped whole, leaves the current page unchanged, and sets status bit 0.
- R6: Writing 1 to status bit 0 or bit 4 clears that flag. Writing 0 leaves it unchanged.
- R7: Writing 1 to bit 0 of the window register opens the window at word 0 of page (boundary + 1). Each data-port read returns the next word, and the read pointer wraps from the last word of the ring to word 0.
- R8: A data-port read while the window is closed returns 0.
- R9: The boundary register stores the low PAGE_W bits of a write. Writes to the current-page register have no effect.
- R10: `irq` is high exactly when the receive or overflow flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame beat valid |
| in_data | input | 32 | Frame beat data, little-endian bytes |
| in_last | input | 1 | Last beat of a frame |
| in_tail | input | 2 | Valid bytes in the last beat (0 means 4) |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 3 | Host register index |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, valid one cycle after reg_rd |
| irq | output | 1 | Receive or overflow pending |

## Verification
The assertions assume a host that never reads a register and writes the window or status in the same cycle. They also assume the host never moves the boundary past the current pointer. The stimulus keeps each register access alone in its cycle, with idle cycles between host operations. It advances the boundary only by the page count of a packet it has just drained. Frames and host accesses never overlap, so a flag set and a flag clear never fall on the same edge.

// File: rtl/rx_page_ring.sv
module rx_page_ring #(
  parameter int PAGE_W  = 9,
  parameter int MAX_LEN = 15360
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  input  logic        in_last,
  input  logic [1:0]  in_tail,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int WORD_AW = PAGE_W + 2;
  localparam int DEPTH   = 1 << WORD_AW;
  localparam logic [PAGE_W-1:0]  ONE_PG = 1;
  localparam logic [WORD_AW-1:0] ONE_WD = 1;
  localparam logic [2:0] A_STAT = 3'd0, A_CUR = 3'd1, A_BND = 3'd2, A_WIN = 3'd3, A_DATA = 3'd4;

  logic [31:0]        mem [DEPTH];
  logic [PAGE_W-1:0]  cur_pg, bnd_pg;
  logic [WORD_AW-1:0] rptr, fr_wptr, beat_addr;
  logic               win, flag_ovf, flag_rx, fr_busy, fr_drop;
  logic [16:0]        fr_cnt, cnt_next, need_pg;
  logic [2:0]         beat_bytes;
  logic [PAGE_W-1:0]  free_pg;
  logic               bad, take, commit, drop_now, stat_clr;
  logic               unused_wdata;

  assign beat_bytes = (in_last && in_tail != 2'd0) ? {1'b0, in_tail} : 3'd4;
  assign cnt_next   = fr_cnt + 17'(beat_bytes);
  assign need_pg    = 17'd1 + ((cnt_next + 17'd15) >> 4);
  assign free_pg    = bnd_pg - cur_pg;
  assign bad        = (cnt_next > 17'(MAX_LEN)) || (need_pg > 17'(free_pg));
  assign take       = in_valid && !fr_drop && !bad;
  assign commit     = take && in_last;
  assign drop_now   = in_valid && !fr_drop && bad;
  assign beat_addr  = fr_busy ? fr_wptr : {cur_pg, 2'b01};
  assign stat_clr   = reg_wr && reg_addr == A_STAT;
  assign irq        = flag_rx | flag_ovf;
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (take)   mem[beat_addr] <= in_data;
    if (commit) mem[{cur_pg, 2'b00}] <= {16'h0, cnt_next[15:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fr_busy <= 1'b0;
      fr_drop <= 1'b0;
      fr_cnt  <= '0;
      fr_wptr <= '0;
      cur_pg  <= '0;
    end else begin
      if (in_valid) begin
        if (in_last) begin
          fr_busy <= 1'b0;
          fr_drop <= 1'b0;
          fr_cnt  <= '0;
        end else begin
          fr_busy <= 1'b1;
          fr_drop <= fr_drop | bad;
          fr_cnt  <= fr_drop ? fr_cnt : cnt_next;
          fr_wptr <= beat_addr + ONE_WD;
        end
      end
      if (commit) cur_pg <= cur_pg + need_pg[PAGE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bnd_pg    <= '1;
      win       <= 1'b0;
      rptr      <= '0;
      flag_ovf  <= 1'b0;
      flag_rx   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      flag_ovf <= drop_now | (flag_ovf & ~(stat_clr & reg_wdata[0]));
      flag_rx  <= commit   | (flag_rx  & ~(stat_clr & reg_wdata[4]));
      if (reg_wr) begin
        case (reg_addr)
          A_BND: bnd_pg <= reg_wdata[PAGE_W-1:0];
          A_WIN: begin
            win <= reg_wdata[0];
            if (reg_wdata[0]) rptr <= {bnd_pg + ONE_PG, 2'b00};
          end
          default: ;
        endcase
      end
      if (reg_rd) begin
        case (reg_addr)
          A_STAT: reg_rdata <= {27'h0, flag_rx, 3'b000, flag_ovf};
          A_CUR:  reg_rdata <= 32'(cur_pg);
          A_BND:  reg_rdata <= 32'(bnd_pg);
          A_WIN:  reg_rdata <= {31'h0, win};
          A_DATA: begin
            if (win) begin
              reg_rdata <= mem[rptr];
              rptr      <= rptr + ONE_WD;
            end else begin
              reg_rdata <= '0;
            end
          end
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  assert_cur_stable_on_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (fr_drop || bad)) |=> $stable(cur_pg));

  assert_rx_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_rx) |-> $past(in_valid && in_last));

  assert_closed_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_DATA && !win) |=> reg_rdata == 32'h0);

  assert_ovf_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STAT && reg_wdata[0] && !drop_now) |=> !flag_ovf);

  assert_bnd_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_BND) |=> bnd_pg == $past(reg_wdata[PAGE_W-1:0]));
endmodule

// File: tb/rx_page_ring_bench.sv
module rx_page_ring_bench;
  localparam int CLK_P = 10;
  localparam int PW    = 4;
  localparam int MAXL  = 100;
  localparam int MASK  = (1 << PW) - 1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic [31:0] in_data = '0;
  logic [1:0]  in_tail = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  rx_page_ring #(.PAGE_W(PW), .MAX_LEN(MAXL)) u_rx_page_ring (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_tail(in_tail), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0;
  int m_cur = 0, m_bnd = MASK;
  bit m_ovf = 0, m_rx = 0, m_win = 0;
  int q_len[$];
  int q_seed[$];
  logic [31:0] exp_w[$];
  logic [31:0] exp_m[$];

  function automatic logic [7:0] pb(int seed, int k);
    return 8'((seed + k * 7) & 255);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R10: interrupt compared with the model on every clock
  bit irq_e;
  always @(posedge clk) begin
    irq_e = m_rx | m_ovf;
    #2;
    if (rst_n) chk(irq === irq_e, "R10 irq", {31'h0, irq}, {31'h0, irq_e});
  end

  task automatic send_frame(int len, int seed);
    int beats;
    int freep;
    bit dropped;
    beats = (len + 3) / 4;
    freep = (m_bnd - m_cur) & MASK;
    dropped = 0;
    for (int i = 0; i < beats; i++) begin
      logic [31:0] d;
      int cnt;
      int need;
      d = '0;
      @(negedge clk);
      for (int b = 0; b < 4; b++)
        if (4 * i + b < len) d[8*b +: 8] = pb(seed, 4 * i + b);
      in_valid = 1'b1;
      in_data  = d;
      in_last  = (i == beats - 1);
      in_tail  = 2'(len % 4);
      cnt  = (i == beats - 1) ? len : 4 * (i + 1);
      need = 1 + (cnt + 15) / 16;
      if (!dropped && (cnt > MAXL || need > freep)) begin
        dropped = 1;
        m_ovf = 1;
      end
      if (i == beats - 1 && !dropped) begin
        q_len.push_back(len);
        q_seed.push_back(seed);
        m_cur = (m_cur + need) & MASK;
        m_rx = 1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic reg_write(logic [2:0] a, logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    case (a)
      3'd0: begin
        if (v[0]) m_ovf = 0;
        if (v[4]) m_rx = 0;
      end
      3'd2: m_bnd = v & MASK;
      3'd3: begin
        m_win = v[0];
        if (v[0]) begin
          exp_w.delete();
          exp_m.delete();
          if (q_len.size() > 0) begin
            exp_w.push_back(32'(q_len[0]));
            exp_m.push_back(32'hFFFF_FFFF);
            for (int w = 0; w < (q_len[0] + 3) / 4; w++) begin
              logic [31:0] ev;
              logic [31:0] em;
              ev = '0; em = '0;
              for (int b = 0; b < 4; b++)
                if (4 * w + b < q_len[0]) begin
                  ev[8*b +: 8] = pb(q_seed[0], 4 * w + b);
                  em[8*b +: 8] = 8'hFF;
                end
              exp_w.push_back(ev);
              exp_m.push_back(em);
            end
          end
        end
      end
      default: ;
    endcase
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, logic [31:0] exp, logic [31:0] msk, string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(((reg_rdata ^ exp) & msk) == 0, tag, reg_rdata, exp);
  endtask

  function automatic logic [31:0] stat_exp();
    return {27'h0, m_rx, 3'b000, m_ovf};
  endfunction

  task automatic drain_one();
    int len;
    len = q_len[0];
    reg_read(3'd1, 32'(m_cur), 32'hFFFF_FFFF, "R3 current page");
    reg_read(3'd2, 32'(m_bnd), 32'hFFFF_FFFF, "R9 boundary");
    reg_write(3'd3, 32'h1);
    reg_read(3'd4, exp_w.pop_front(), exp_m.pop_front(), "R2 length header");
    while (exp_w.size() > 0)
      reg_read(3'd4, exp_w.pop_front(), exp_m.pop_front(), "R2 R7 payload word");
    reg_write(3'd3, 32'h0);
    reg_write(3'd2, 32'((m_bnd + 1 + (len + 15) / 16) & MASK));
    void'(q_len.pop_front());
    void'(q_seed.pop_front());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, run incomplete (R1 to R10)");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    reg_read(3'd0, 32'h0, 32'hFFFF_FFFF, "R1 status after reset");
    reg_read(3'd1, 32'h0, 32'hFFFF_FFFF, "R1 current after reset");
    reg_read(3'd2, 32'(MASK), 32'hFFFF_FFFF, "R1 boundary after reset");
    // R8 data port with closed window
    reg_read(3'd4, 32'h0, 32'hFFFF_FFFF, "R8 closed window read");
    // R3 two frames, partial and full tails
    send_frame(5, 16);
    reg_read(3'd1, 32'(m_cur), 32'hFFFF_FFFF, "R3 current after 5-byte frame");
    send_frame(32, 64);
    reg_read(3'd0, stat_exp(), 32'hFFFF_FFFF, "R3 receive flag");
    drain_one();
    drain_one();
    // R6 clear receive flag
    reg_write(3'd0, 32'h10);
    reg_read(3'd0, stat_exp(), 32'hFFFF_FFFF, "R6 receive flag cleared");
    // R9 boundary masking, current page read-only
    reg_write(3'd2, 32'h35);
    reg_read(3'd2, 32'h5, 32'hFFFF_FFFF, "R9 boundary masked");
    reg_write(3'd2, 32'h4);
    reg_write(3'd1, 32'h7);
    reg_read(3'd1, 32'(m_cur), 32'hFFFF_FFFF, "R9 current page ignores write");
    // R4 fill, then overflow with a frame that does not fit
    send_frame(100, 119);
    send_frame(100, 34);
    reg_read(3'd0, stat_exp(), 32'hFFFF_FFFF, "R4 overflow flag");
    reg_read(3'd1, 32'(m_cur), 32'hFFFF_FFFF, "R4 current unchanged after drop");
    reg_write(3'd0, 32'h01);
    reg_read(3'd0, stat_exp(), 32'hFFFF_FFFF, "R6 overflow flag cleared");
    // R4 exact fit, then a full ring refuses a tiny frame
    send_frame(96, 90);
    reg_read(3'd1, 32'(m_cur), 32'hFFFF_FFFF, "R4 exact fit accepted");
    send_frame(4, 51);
    reg_read(3'd0, stat_exp(), 32'hFFFF_FFFF, "R4 full ring drops frame");
    // R7 drain including the wrapped packet
    drain_one();
    drain_one();
    reg_read(3'd1, 32'(m_cur), 32'hFFFF_FFFF, "R7 ring empty after wrap drain");
    reg_write(3'd0, 32'h11);
    reg_read(3'd0, 32'h0, 32'hFFFF_FFFF, "R6 both flags cleared");
    // R5 overlong frame with room available
    send_frame(104, 97);
    reg_read(3'd0, stat_exp(), 32'hFFFF_FFFF, "R5 overlong sets overflow");
    reg_read(3'd1, 32'(m_cur), 32'hFFFF_FFFF, "R5 current unchanged");
    reg_write(3'd0, 32'h01);
    // R2 single-byte frame
    send_frame(1, 144);
    drain_one();
    reg_read(3'd4, 32'h0, 32'hFFFF_FFFF, "R8 read after window closed");
    reg_write(3'd0, 32'h10);
    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule